// File: doc/BRIEF.md
# Memory-Reference Instruction Executor

This unit runs the memory-reference instructions of a 12-bit, word-oriented accumulator machine. An outer control sequencer fetches an instruction word, then pulses `start` with that word, the program counter (already advanced past the instruction), the accumulator and the link bit. The unit builds the effective address, follows one level of indirection when asked, and drives a single-port synchronous memory. It then returns the new accumulator, link and program counter with a one-clock `done` pulse, and the sequencer can fetch the next instruction.

An instruction word holds the opcode in bits [11:9], the indirect flag in bit 8, the page select in bit 7 and a 7-bit offset in bits [6:0]. A clear page select addresses page zero, which is the offset zero-extended. A set page select addresses the current page, formed as PC[11:7] followed by the offset. The six opcodes handled are: 0 logical AND, 1 two's-complement add, 2 increment-and-skip-if-zero, 3 store-and-clear, 4 subroutine call and 5 jump. Opcodes 6 and 7 belong to other units and pass through untouched.

Top module: `mre_exec`

## Requirements
- R1: The effective address is the 7-bit offset zero-extended when bit 7 is 0, and {PC[11:7], offset} when bit 7 is 1.
- R2: When bit 8 is set, the unit reads the word at the effective address and uses that word as the final address. This costs two extra cycles and happens only once.
- R3: Opcode 0 replaces the accumulator with the accumulator ANDed with the operand, and leaves the link unchanged.
- R4: Opcode 1 replaces the accumulator with the 12-bit sum of accumulator and operand. A carry out of bit 11 complements the link.
- R5: Opcode 2 writes operand+1 (mod 4096) back to the same address. When that value is zero, the PC advances by one more. The accumulator and link are unchanged.
- R6: Opcode 3 writes the accumulator to the effective address and returns an accumulator of zero.
- R7: Opcode 4 writes the incoming PC to the effective address and returns PC = address+1 (mod 4096).
- R8: Opcode 5 returns PC = effective address with no memory write. Opcodes 6 and 7 finish in one cycle and return all state unchanged.
- R9: `done` is high for exactly one cycle per instruction. Counting from the start edge, it rises after 1 (jump, opcode 6/7), 2 (store, call), 3 (AND, add) or 4 (increment) edges, plus 2 when indirect. Each write asserts `mem_we` for a single cycle, and AND, add and jump never write.
- R10: `start` is ignored while an instruction is in progress, and the inputs captured at acceptance stay in use.
- R11: Reset, including reset in the middle of an instruction, returns the unit to idle with `done` and `mem_we` low and no further write.
- R12: The memory reads synchronously: `mem_rdata` holds the word at `mem_addr` one edge after the address is presented. A write takes place at the edge where `mem_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr`; sampled only when idle |
| instr | input | 12 | Instruction word |
| pc_in | input | 12 | PC pointing past the instruction |
| acc_in | input | 12 | Accumulator before the instruction |
| link_in | input | 1 | Link bit before the instruction |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 12 | Memory read data, one edge after the address |
| acc_out | output | 12 | Resulting accumulator, valid with `done` |
| link_out | output | 1 | Resulting link, valid with `done` |
| pc_out | output | 12 | Resulting PC, valid with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest paths to reach are the ones where the address read back through indirection leads to a wrap-around: a call whose pointer is 0xFFF, so the return PC wraps to zero, and an increment-and-skip that overflows to zero with the PC at 0xFFF. The vector table builds these cases by preloading both the pointer word and its target in the bench memory. A reset in the middle of an increment, and a held `start` during a busy instruction, are driven as directed sequences. After each of them the bench watches the write counter and the returned state.

// File: rtl/mre_pkg.sv
package mre_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IND_A,
        ST_IND_D,
        ST_OPD_A,
        ST_OPD_D,
        ST_WRITE,
        ST_FINISH
    } mre_state_e;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_IOT = 3'd6,
        OP_OPR = 3'd7
    } mre_op_e;

endpackage

// File: rtl/mre_ea_form.sv
module mre_ea_form #(
    parameter int WORD_W = 12,
    parameter int OFF_W  = 7
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] ea,
    output logic              indirect
);
    localparam int PG_BIT  = OFF_W;
    localparam int IND_BIT = OFF_W + 1;
    localparam int PAGE_W  = WORD_W - OFF_W;

    logic [PAGE_W-1:0] page_sel;

    always_comb begin
        page_sel = instr[PG_BIT] ? pc[WORD_W-1:OFF_W] : {PAGE_W{1'b0}};
        ea       = {page_sel, instr[OFF_W-1:0]};
        indirect = instr[IND_BIT];
    end

    // Page-zero accesses always land in the low page
    always_comb begin
        if (!instr[PG_BIT])
            AST_PAGE_ZERO: assert (ea[WORD_W-1:OFF_W] == '0); // R1
    end
endmodule

// File: rtl/mre_alu.sv
module mre_alu
    import mre_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  mre_op_e           op,
    input  logic [WORD_W-1:0] acc,
    input  logic              link,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] acc_nx,
    output logic              link_nx,
    output logic [WORD_W-1:0] inc_val,
    output logic              inc_zero
);
    logic [WORD_W:0] sum_ext;

    always_comb begin
        sum_ext  = {1'b0, acc} + {1'b0, opnd};
        inc_val  = opnd + {{(WORD_W-1){1'b0}}, 1'b1};
        inc_zero = (inc_val == '0);
        acc_nx   = acc;
        link_nx  = link;
        case (op)
            OP_AND: acc_nx = acc & opnd;
            OP_TAD: begin
                acc_nx  = sum_ext[WORD_W-1:0];
                link_nx = link ^ sum_ext[WORD_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mre_exec.sv
module mre_exec
    import mre_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int OP_W   = 3,
    parameter int OFF_W  = WORD_W - OP_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] acc_in,
    input  logic              link_in,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] acc_out,
    output logic              link_out,
    output logic [WORD_W-1:0] pc_out,
    output logic              done
);
    localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        mre_state_e        st;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] acc;
        logic              lnk;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] maddr;
        logic [WORD_W-1:0] wdata;
        logic              we;
    } regs_t;

    regs_t r_q, r_d;

    logic [WORD_W-1:0] ea_dir;
    logic              ind_dir;
    mre_op_e           op_q;
    logic [WORD_W-1:0] alu_acc, alu_inc;
    logic              alu_lnk, alu_zero;

    assign op_q = mre_op_e'(r_q.ir[WORD_W-1 -: OP_W]);

    mre_ea_form #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_ea (
        .instr    (instr),
        .pc       (pc_in),
        .ea       (ea_dir),
        .indirect (ind_dir)
    );

    mre_alu #(.WORD_W(WORD_W)) u_alu (
        .op       (op_q),
        .acc      (r_q.acc),
        .link     (r_q.lnk),
        .opnd     (mem_rdata),
        .acc_nx   (alu_acc),
        .link_nx  (alu_lnk),
        .inc_val  (alu_inc),
        .inc_zero (alu_zero)
    );

    // Route to the operation once the final address is known
    function automatic regs_t dispatch(input regs_t r, input logic [WORD_W-1:0] e);
        regs_t n;
        n = r;
        case (mre_op_e'(r.ir[WORD_W-1 -: OP_W]))
            OP_AND, OP_TAD, OP_ISZ: begin
                n.maddr = e;
                n.st    = ST_OPD_A;
            end
            OP_DCA: begin
                n.maddr = e;
                n.wdata = r.acc;
                n.we    = 1'b1;
                n.acc   = '0;
                n.st    = ST_WRITE;
            end
            OP_JMS: begin
                n.maddr = e;
                n.wdata = r.pc;
                n.we    = 1'b1;
                n.pc    = e + ONE;
                n.st    = ST_WRITE;
            end
            OP_JMP: begin
                n.pc = e;
                n.st = ST_FINISH;
            end
            default: n.st = ST_FINISH;
        endcase
        return n;
    endfunction

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.ir  = instr;
                    r_d.acc = acc_in;
                    r_d.lnk = link_in;
                    r_d.pc  = pc_in;
                    if (ind_dir && (instr[WORD_W-1 -: OP_W] <= OP_W'(OP_JMP))) begin
                        r_d.maddr = ea_dir;
                        r_d.st    = ST_IND_A;
                    end else begin
                        r_d = dispatch(r_d, ea_dir);
                    end
                end
            end
            ST_IND_A:  r_d.st = ST_IND_D;
            ST_IND_D:  r_d = dispatch(r_d, mem_rdata);
            ST_OPD_A:  r_d.st = ST_OPD_D;
            ST_OPD_D: begin
                if (op_q == OP_ISZ) begin
                    r_d.wdata = alu_inc;
                    r_d.we    = 1'b1;
                    if (alu_zero)
                        r_d.pc = r_q.pc + ONE;
                    r_d.st = ST_WRITE;
                end else begin
                    r_d.acc = alu_acc;
                    r_d.lnk = alu_lnk;
                    r_d.st  = ST_FINISH;
                end
            end
            ST_WRITE:  r_d.st = ST_FINISH;
            ST_FINISH: r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.maddr;
    assign mem_wdata = r_q.wdata;
    assign mem_we    = r_q.we;
    assign acc_out   = r_q.acc;
    assign link_out  = r_q.lnk;
    assign pc_out    = r_q.pc;
    assign done      = (r_q.st == ST_FINISH);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R9
    AST_NO_WRITE_READOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_AND || op_q == OP_TAD || op_q == OP_JMP) && r_q.st != ST_IDLE |-> !mem_we); // R9
    AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done && op_q == OP_DCA |-> acc_out == '0); // R6
    AST_BUSY_HOLDS_IR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.st != ST_FINISH) |=> $stable(r_q.ir)); // R10
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done); // R9
endmodule

// File: tb/sim_mre_exec.sv
module sim_mre_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr = '0, pc_in = '0, acc_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, done;
    logic [11:0] acc_out, pc_out;
    logic        link_out;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;
    logic [11:0] mem [4096];

    always #10 clk = ~clk;

    mre_exec u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
        .acc_in(acc_in), .link_in(link_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .acc_out(acc_out), .link_out(link_out),
        .pc_out(pc_out), .done(done)
    );

    // Synchronous single-port memory model (R12)
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    typedef struct packed {
        logic [11:0] ins, pc, acc;
        logic        lnk;
        logic [11:0] a1, d1, a2, d2;
        logic [11:0] e_acc;
        logic        e_lnk;
        logic [11:0] e_pc, c_addr, c_val;
        logic [3:0]  cyc;
        logic [1:0]  wr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{12'h010,12'h205,12'hF0F,1'b0,12'h010,12'h3C3,12'h010,12'h3C3,12'h303,1'b0,12'h205,12'h010,12'h3C3,4'd3,2'd0}, // R3 R1 page zero
        '{12'h285,12'h4A3,12'h456,1'b0,12'h485,12'h123,12'h485,12'h123,12'h579,1'b0,12'h4A3,12'h485,12'h123,4'd3,2'd0}, // R4 R1 current page
        '{12'h211,12'h100,12'hFFF,1'b1,12'h011,12'h001,12'h011,12'h001,12'h000,1'b0,12'h100,12'h011,12'h001,4'd3,2'd0}, // R4 carry flips link
        '{12'h320,12'h300,12'h900,1'b0,12'h020,12'h7A0,12'h7A0,12'h800,12'h100,1'b1,12'h300,12'h7A0,12'h800,4'd5,2'd0}, // R2 R4 indirect
        '{12'h430,12'h050,12'h777,1'b1,12'h030,12'h005,12'h030,12'h005,12'h777,1'b1,12'h050,12'h030,12'h006,4'd4,2'd1}, // R5 no skip
        '{12'h431,12'h050,12'h777,1'b0,12'h031,12'hFFF,12'h031,12'hFFF,12'h777,1'b0,12'h051,12'h031,12'h000,4'd4,2'd1}, // R5 skip
        '{12'h68A,12'hC15,12'hABC,1'b1,12'hC0A,12'h111,12'hC0A,12'h111,12'h000,1'b1,12'hC15,12'hC0A,12'hABC,4'd2,2'd1}, // R6 R1
        '{12'h840,12'h321,12'h005,1'b0,12'h040,12'h000,12'h040,12'h000,12'h005,1'b0,12'h041,12'h040,12'h321,4'd2,2'd1}, // R7
        '{12'hB92,12'h2F0,12'h0AA,1'b1,12'h292,12'h9AB,12'h292,12'h9AB,12'h0AA,1'b1,12'h9AB,12'h292,12'h9AB,4'd3,2'd0}, // R8 R2
        '{12'hA7F,12'h555,12'h000,1'b0,12'h07F,12'h246,12'h07F,12'h246,12'h000,1'b0,12'h07F,12'h07F,12'h246,4'd1,2'd0}, // R8 direct
        '{12'h515,12'hFFF,12'h321,1'b0,12'h015,12'h3F0,12'h3F0,12'hFFF,12'h321,1'b0,12'h000,12'h3F0,12'h000,4'd6,2'd1}, // R5 R2 wrap
        '{12'h716,12'h600,12'h002,1'b0,12'h016,12'h444,12'h444,12'h999,12'h000,1'b0,12'h600,12'h444,12'h002,4'd4,2'd1}, // R6 R2
        '{12'h981,12'h0C2,12'h010,1'b1,12'h081,12'hFFF,12'hFFF,12'h000,12'h010,1'b1,12'h000,12'hFFF,12'h0C2,4'd4,2'd1}  // R7 R2 wrap
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    // Launch at a negedge, count edges until done is seen
    task automatic run(input logic [11:0] i, p, a, input logic l, output int cyc);
        instr = i; pc_in = p; acc_in = a; link_in = l; start = 1'b1;
        cyc = 0;
        @(posedge clk); cyc++;
        #1 start = 1'b0;
        @(negedge clk);
        while (!done && cyc < 20) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #2000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int cyc, w0;
        for (int k = 0; k < 4096; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        check("R11 done in reset", {11'd0, done}, 12'd0);
        check("R11 we in reset", {11'd0, mem_we}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            mem[VEC[v].a1] = VEC[v].d1;
            mem[VEC[v].a2] = VEC[v].d2;
            w0 = wr_cnt;
            run(VEC[v].ins, VEC[v].pc, VEC[v].acc, VEC[v].lnk, cyc);
            check($sformatf("R9 latency v%0d", v), 12'(cyc), {8'd0, VEC[v].cyc});
            check($sformatf("acc v%0d", v), acc_out, VEC[v].e_acc);
            check($sformatf("link v%0d", v), {11'd0, link_out}, {11'd0, VEC[v].e_lnk});
            check($sformatf("pc v%0d", v), pc_out, VEC[v].e_pc);
            @(negedge clk);
            check($sformatf("R9 done pulse v%0d", v), {11'd0, done}, 12'd0);
            check($sformatf("mem v%0d", v), mem[VEC[v].c_addr], VEC[v].c_val);
            check($sformatf("R9 writes v%0d", v), 12'(wr_cnt - w0), {10'd0, VEC[v].wr});
        end

        // R10: start held high with different inputs while busy
        mem[12'h010] = 12'h0FF;
        instr = 12'h010; pc_in = 12'h200; acc_in = 12'hFFF; link_in = 1'b0; start = 1'b1;
        @(posedge clk); #1;
        instr = 12'hA7F; pc_in = 12'h555; acc_in = 12'h000;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check("R10 not done yet", {11'd0, done}, 12'd0);
        @(negedge clk);
        check("R10 done", {11'd0, done}, 12'd1);
        check("R10 acc from first", acc_out, 12'h0FF);
        check("R10 pc from first", pc_out, 12'h200);
        @(negedge clk);
        @(negedge clk);
        check("R10 no second run", {11'd0, done}, 12'd0);

        // R8: opcode 6 passes through
        w0 = wr_cnt;
        run(12'hC00, 12'h456, 12'h123, 1'b1, cyc);
        check("R8 op6 latency", 12'(cyc), 12'd1);
        check("R8 op6 acc", acc_out, 12'h123);
        check("R8 op6 pc", pc_out, 12'h456);
        check("R8 op6 link", {11'd0, link_out}, 12'd1);
        check("R8 op6 writes", 12'(wr_cnt - w0), 12'd0);
        @(negedge clk);

        // R11: reset in the middle of an increment
        mem[12'h033] = 12'h00F;
        w0 = wr_cnt;
        instr = 12'h433; pc_in = 12'h100; acc_in = 12'h0; link_in = 1'b0; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 no write after reset", 12'(wr_cnt - w0), 12'd0);
        check("R11 memory intact", mem[12'h033], 12'h00F);
        check("R11 done low", {11'd0, done}, 12'd0);
        check("R11 we low", {11'd0, mem_we}, 12'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule